// File: doc/BRIEF.md
# Virtual Page Hash Generator

This block turns a translation request into the two numbers a hashed page table walker needs: the virtual page number (the virtual address with its 12 offset bits dropped) and a 39-bit hash that selects the group of entries to search. A request carries the effective page number (the effective address shifted right by 12, limited to the bits the largest segment can index), the segment's virtual segment identifier, a segment-size code and the page size as a shift count.

Two segment sizes are supported. A 256 MB segment keeps 16 page-index bits below the identifier. A 1 TB segment keeps 28 page-index bits, and its hash mixes the identifier with a copy of itself moved up 25 places. The page index is moved right by the page shift minus 12 before it enters the hash. Larger page sizes therefore contribute fewer index bits.

The work is split over two register stages. The first builds the page number and screens the request. The second folds the hash. A new request may enter every cycle. Cutting the hash down to the table size and forming the secondary (complemented) hash are left to the consumer.

Top module: `vph_gen`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_valid` and `out_err` are 0 and `out_vpn` and `out_hash` are 0.
- R2: A request presented with `in_valid` high at a rising edge appears on the outputs after the second following rising edge. Back-to-back requests produce back-to-back results in order.
- R3: For segment code 0 (256 MB), `out_vpn` = (VSID << 16) | EPN[15:0], truncated to 64 bits.
- R4: For segment code 1 (1 TB), `out_vpn` = (VSID << 28) | EPN[27:0], truncated to 64 bits.
- R5: For code 0, `out_hash` = low 39 bits of (VPN >> 16) XOR (VPN[15:0] >> (pshift − 12)).
- R6: For code 1, with S = VPN >> 28, `out_hash` = low 39 bits of S XOR (S << 25) XOR (VPN[27:0] >> (pshift − 12)).
- R7: Hash bits above bit 38 are discarded, including identifier bits that reach them.
- R8: A page shift below 12 gives `out_valid` = 1 with `out_err` = 1, and `out_vpn` = 0 and `out_hash` = 0.
- R9: Segment codes 2 and 3 are reserved. They give `out_err` = 1 with zero `out_vpn` and `out_hash`, whatever the page shift.
- R10: A page shift that moves the whole page index out (for example 40 with code 0) leaves only the segment part in the hash.
- R11: When no request was taken two edges earlier, `out_valid` and `out_err` are 0 and `out_vpn` and `out_hash` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present this cycle |
| in_epn | input | EPN_W (28) | Effective address bits 39..12 |
| in_vsid | input | VSID_W (52) | Virtual segment identifier |
| in_seg | input | 2 | Segment code: 0 = 256 MB, 1 = 1 TB, 2/3 reserved |
| in_pshift | input | PS_W (6) | Page size as log2 of bytes |
| out_valid | output | 1 | Result present |
| out_err | output | 1 | Request rejected (reserved code or shift below 12) |
| out_vpn | output | VPN_W (64) | Virtual page number |
| out_hash | output | HASH_W (39) | Primary hash value |

## Verification
The bench aims at the places where the two segment sizes differ. A design that mixes up the 16-bit and 28-bit index widths, or that leaves out the 25-bit self-fold, gives wrong hashes on any 1 TB request. Identifiers with every bit set expose a hash that is not cut to 39 bits. A page shift of 12 checks that the shift amount is not off by one, and very large shifts check that the index contribution drops to zero rather than wrapping. Shifts of 0 and 11, and both reserved codes, must raise the error flag with cleared data. Idle cycles placed between back-to-back requests catch a valid flag that sticks or a stage that is skipped.

// File: rtl/vph_pkg.sv
package vph_pkg;
  localparam int VPN_SHIFT      = 12;
  localparam int SEG_SHIFT_256M = 28;
  localparam int SEG_SHIFT_1T   = 40;
  localparam int ONE_T_FOLD     = 25;
  localparam int NUM_SEG        = 2;

  typedef enum logic [1:0] {
    SEG_256M  = 2'd0,
    SEG_1T    = 2'd1,
    SEG_RSVD2 = 2'd2,
    SEG_RSVD3 = 2'd3
  } seg_code_e;

  // page-index bits held below the identifier for segment kind k
  function automatic int seg_index_bits(int k);
    return ((k == 0) ? SEG_SHIFT_256M : SEG_SHIFT_1T) - VPN_SHIFT;
  endfunction

  // self-fold distance of the segment part for kind k (0 = none)
  function automatic int seg_fold(int k);
    return (k == 0) ? 0 : ONE_T_FOLD;
  endfunction
endpackage

// File: rtl/vph_vpn_build.sv
module vph_vpn_build
  import vph_pkg::*;
#(
  parameter int EPN_W  = 28,
  parameter int VSID_W = 52,
  parameter int VPN_W  = 64,
  parameter int PS_W   = 6
) (
  input  logic [EPN_W-1:0]  epn,
  input  logic [VSID_W-1:0] vsid,
  input  logic [1:0]        seg,
  input  logic [PS_W-1:0]   pshift,
  output logic [VPN_W-1:0]  vpn,
  output logic              seg_1t,
  output logic [PS_W-1:0]   idx_shift,
  output logic              bad_seg,
  output logic              bad_shift
);
  logic [VPN_W-1:0] cand [NUM_SEG];

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    localparam int IB = seg_index_bits(g);
    assign cand[g] = (VPN_W'(vsid) << IB) | VPN_W'(epn[IB-1:0]);
  end

  always_comb begin
    bad_seg   = (seg == SEG_RSVD2) || (seg == SEG_RSVD3);
    bad_shift = pshift < PS_W'(VPN_SHIFT);
    seg_1t    = (seg == SEG_1T);
    vpn       = seg_1t ? cand[1] : cand[0];
    idx_shift = bad_shift ? '0 : pshift - PS_W'(VPN_SHIFT);
  end
endmodule

// File: rtl/vph_hash_fold.sv
module vph_hash_fold
  import vph_pkg::*;
#(
  parameter int VPN_W  = 64,
  parameter int PS_W   = 6,
  parameter int HASH_W = 39
) (
  input  logic [VPN_W-1:0]  vpn,
  input  logic              seg_1t,
  input  logic [PS_W-1:0]   idx_shift,
  output logic [HASH_W-1:0] hash
);
  logic [HASH_W-1:0] cand [NUM_SEG];

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_fold
    localparam int IB   = seg_index_bits(g);
    localparam int FOLD = seg_fold(g);
    logic [VPN_W-1:0] segp, folded, idx;
    assign segp   = vpn >> IB;
    assign folded = (FOLD == 0) ? segp : (segp ^ (segp << FOLD));
    assign idx    = (vpn & ((VPN_W'(1) << IB) - VPN_W'(1))) >> idx_shift;
    assign cand[g] = HASH_W'(folded ^ idx);
  end

  assign hash = seg_1t ? cand[1] : cand[0];
endmodule

// File: rtl/vph_gen.sv
module vph_gen
  import vph_pkg::*;
#(
  parameter int EPN_W  = 28,
  parameter int VSID_W = 52,
  parameter int VPN_W  = 64,
  parameter int PS_W   = 6,
  parameter int HASH_W = 39
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [EPN_W-1:0]  in_epn,
  input  logic [VSID_W-1:0] in_vsid,
  input  logic [1:0]        in_seg,
  input  logic [PS_W-1:0]   in_pshift,
  output logic              out_valid,
  output logic              out_err,
  output logic [VPN_W-1:0]  out_vpn,
  output logic [HASH_W-1:0] out_hash
);
  // stage 1: page number build and screening
  logic [VPN_W-1:0] b_vpn;
  logic             b_1t, b_bad_seg, b_bad_shift;
  logic [PS_W-1:0]  b_shift;

  vph_vpn_build #(.EPN_W(EPN_W), .VSID_W(VSID_W), .VPN_W(VPN_W), .PS_W(PS_W)) u_build (
    .epn(in_epn), .vsid(in_vsid), .seg(in_seg), .pshift(in_pshift),
    .vpn(b_vpn), .seg_1t(b_1t), .idx_shift(b_shift),
    .bad_seg(b_bad_seg), .bad_shift(b_bad_shift)
  );

  logic             s1_valid, s1_err, s1_1t;
  logic [VPN_W-1:0] s1_vpn;
  logic [PS_W-1:0]  s1_shift;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_err   <= 1'b0;
      s1_1t    <= 1'b0;
      s1_vpn   <= '0;
      s1_shift <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_err   <= in_valid && (b_bad_seg || b_bad_shift);
      s1_1t    <= b_1t;
      s1_vpn   <= b_vpn;
      s1_shift <= b_shift;
    end
  end

  // stage 2: hash fold, registered outputs
  logic [HASH_W-1:0] f_hash;

  vph_hash_fold #(.VPN_W(VPN_W), .PS_W(PS_W), .HASH_W(HASH_W)) u_fold (
    .vpn(s1_vpn), .seg_1t(s1_1t), .idx_shift(s1_shift), .hash(f_hash)
  );

  logic s1_good;
  assign s1_good = s1_valid && !s1_err;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      out_vpn   <= '0;
      out_hash  <= '0;
    end else begin
      out_valid <= s1_valid;
      out_err   <= s1_err;
      out_vpn   <= s1_good ? s1_vpn : '0;
      out_hash  <= s1_good ? f_hash : '0;
    end
  end
endmodule

// File: rtl/vph_gen_chk.sv
module vph_gen_chk #(
  parameter int VPN_W  = 64,
  parameter int PS_W   = 6,
  parameter int HASH_W = 39
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [15:0]       in_epn_lo,
  input logic [1:0]        in_seg,
  input logic [PS_W-1:0]   in_pshift,
  input logic              out_valid,
  input logic              out_err,
  input logic [VPN_W-1:0]  out_vpn,
  input logic [HASH_W-1:0] out_hash
);
  logic [1:0] cyc_q;
  always_ff @(posedge clk) begin
    if (rst) cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  // R2 R11: valid travels exactly two edges
  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    (cyc_q >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

  // R9: reserved segment codes are rejected
  p_bad_seg_r9: assert property (@(posedge clk) disable iff (rst)
    (cyc_q >= 2'd2 && $past(in_valid && in_seg[1], 2)) |-> (out_err && out_hash == '0 && out_vpn == '0));

  // R8: page shift below 12 is rejected
  p_bad_shift_r8: assert property (@(posedge clk) disable iff (rst)
    (cyc_q >= 2'd2 && $past(in_valid && (in_pshift < PS_W'(12)), 2)) |-> (out_err && out_hash == '0 && out_vpn == '0));

  // R11: idle outputs are quiet
  p_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!out_err && out_hash == '0 && out_vpn == '0));

  // R3: low page number bits come straight from the effective page number
  p_low_vpn_r3: assert property (@(posedge clk) disable iff (rst)
    (cyc_q >= 2'd2 && out_valid && !out_err) |-> (out_vpn[15:0] == $past(in_epn_lo, 2)));
endmodule

bind vph_gen vph_gen_chk #(.VPN_W(VPN_W), .PS_W(PS_W), .HASH_W(HASH_W)) i_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_epn_lo(in_epn[15:0]),
  .in_seg(in_seg), .in_pshift(in_pshift), .out_valid(out_valid),
  .out_err(out_err), .out_vpn(out_vpn), .out_hash(out_hash)
);

// File: tb/test_vph_gen.sv
`timescale 1ns/1ps
module test_vph_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [27:0] in_epn = '0;
  logic [51:0] in_vsid = '0;
  logic [1:0]  in_seg = '0;
  logic [5:0]  in_pshift = '0;
  logic        out_valid, out_err;
  logic [63:0] out_vpn;
  logic [38:0] out_hash;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  vph_gen i_vph_gen (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_epn(in_epn), .in_vsid(in_vsid),
    .in_seg(in_seg), .in_pshift(in_pshift), .out_valid(out_valid), .out_err(out_err),
    .out_vpn(out_vpn), .out_hash(out_hash)
  );

  function automatic logic [63:0] m_vpn(logic [27:0] epn, logic [51:0] vsid, logic [1:0] sg);
    if (sg == 2'd0) return (64'(vsid) << 16) | 64'(epn[15:0]);
    return (64'(vsid) << 28) | 64'(epn);
  endfunction

  function automatic logic [38:0] m_hash(logic [63:0] vpn, logic [1:0] sg, logic [5:0] ps);
    logic [63:0] h, s;
    int sh;
    sh = int'(ps) - 12;
    if (sg == 2'd0) h = (vpn >> 16) ^ ((vpn & 64'hFFFF) >> sh);
    else begin
      s = vpn >> 28;
      h = s ^ (s << 25) ^ ((vpn & 64'hFFF_FFFF) >> sh);
    end
    return h[38:0];
  endfunction

  // expected pipeline: d1 = driven last step, d2 = driven two steps ago
  logic        d1_v = 0, d1_e = 0, d2_v = 0, d2_e = 0;
  logic [63:0] d1_vpn = 0, d2_vpn = 0;
  logic [38:0] d1_h = 0, d2_h = 0;
  string       d1_tag = "R11", d2_tag = "R11";

  task automatic check_now(logic ev, logic ee, logic [63:0] evpn, logic [38:0] eh, string tag);
    n_checks++;
    if (out_valid !== ev || out_err !== ee || out_vpn !== evpn || out_hash !== eh) begin
      n_fail++;
      $display("FAIL %s: got v=%0b e=%0b vpn=%h hash=%h, expected v=%0b e=%0b vpn=%h hash=%h",
               tag, out_valid, out_err, out_vpn, out_hash, ev, ee, evpn, eh);
    end
  endtask

  task automatic step(logic v, logic [27:0] epn, logic [51:0] vsid, logic [1:0] sg,
                      logic [5:0] ps, string tag);
    logic e;
    @(negedge clk);
    check_now(d2_v, d2_e, d2_vpn, d2_h, d2_tag);
    d2_v = d1_v; d2_e = d1_e; d2_vpn = d1_vpn; d2_h = d1_h; d2_tag = d1_tag;
    e = v && (sg[1] || ps < 6'd12);
    d1_v = v;
    d1_e = e;
    d1_vpn = (v && !e) ? m_vpn(epn, vsid, sg) : 64'd0;
    d1_h   = (v && !e) ? m_hash(m_vpn(epn, vsid, sg), sg, ps) : 39'd0;
    d1_tag = v ? tag : "R11";
    in_valid = v; in_epn = epn; in_vsid = vsid; in_seg = sg; in_pshift = ps;
  endtask

  task automatic idle();
    step(1'b0, 28'd0, 52'd0, 2'd0, 6'd0, "R11");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check_now(1'b0, 1'b0, 64'd0, 39'd0, "R1 reset");
    rst = 1'b0;
    @(negedge clk);
    check_now(1'b0, 1'b0, 64'd0, 39'd0, "R1 after reset");

    // directed corners
    step(1, 28'h123_4567, 52'h0_0ABC_DEF1_2345, 2'd0, 6'd12, "R3 R5 4K");
    idle();  // R2: gap then single result
    step(1, 28'h9AB_CDEF, 52'h3_0000_0001_2345, 2'd0, 6'd16, "R5 64K");
    step(1, 28'hFED_CBA9, 52'h0_0012_3456_789A, 2'd1, 6'd12, "R4 R6 4K");
    step(1, 28'h0F0_F0F0, 52'h0_0000_0FFF_FFFF, 2'd1, 6'd24, "R6 16M");
    step(1, 28'hFFF_FFFF, 52'hF_FFFF_FFFF_FFFF, 2'd0, 6'd12, "R7 all ones 256M");
    step(1, 28'hFFF_FFFF, 52'hF_FFFF_FFFF_FFFF, 2'd1, 6'd12, "R7 all ones 1T");
    step(1, 28'h000_FFFF, 52'h0_0000_1234_5678, 2'd0, 6'd40, "R10 index out 256M");
    step(1, 28'hFFF_FFFF, 52'h0_0000_1234_5678, 2'd1, 6'd63, "R10 index out 1T");
    step(1, 28'h555_5555, 52'h1, 2'd0, 6'd11, "R8 shift 11");
    step(1, 28'h555_5555, 52'h1, 2'd1, 6'd0, "R8 shift 0");
    step(1, 28'h111_1111, 52'h77, 2'd2, 6'd12, "R9 code 2");
    step(1, 28'h222_2222, 52'h99, 2'd3, 6'd20, "R9 code 3");
    step(1, 28'h333_3333, 52'h99, 2'd3, 6'd5, "R9 R8 both");
    idle();
    idle();

    // constrained random, back-to-back with bubbles (R2)
    for (int i = 0; i < 400; i++) begin
      logic [1:0] sg;
      logic [5:0] ps;
      logic       v;
      string      tg;
      int         r;
      r  = int'($urandom_range(0, 9));
      sg = (r < 8) ? 2'(r & 1) : 2'(2 + (r & 1));
      ps = ($urandom_range(0, 9) == 0) ? 6'($urandom_range(0, 11)) : 6'($urandom_range(12, 40));
      v  = ($urandom_range(0, 5) != 0);
      if (sg[1]) tg = "R9 random";
      else if (ps < 6'd12) tg = "R8 random";
      else if (sg == 2'd0) tg = "R3 R5 random";
      else tg = "R4 R6 random";
      step(v, 28'($urandom()), {20'($urandom()), 32'($urandom())}, sg, ps, tg);
    end
    idle();
    idle();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    #4_000_000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R2 watchdog: got no completion, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule